// File: doc/BRIEF.md
# Ring-Oscillator Raw Entropy Packer

This block gathers raw random bits from a bank of 128 free-running oscillator sample lines, split into 16 groups of eight, and sends them to a read-side buffer. Only one group is sampled at a time. On each clock cycle the eight lines of that group give one bit each. After eight cycles those 64 bits form one 64-bit word, which goes into a 64-word first-in first-out store (512 bytes). Reads take words out in arrival order, one per request.

Software enables the unit and puts it in raw mode. It picks a group and then drains words. The unit pauses when the store is full and starts again on its own as soon as a word is read, so the store refills without help. A clear input empties the store and holds the unit idle. The first sample each oscillator gives after the unit starts is known to carry no information, so the block forces that bit to zero. The status outputs give the number of stored words and a full flag.

Top module: `ro_entropy_packer`

## Requirements
- R1: The 4-bit group code g on `ctl_group` selects oscillator lines 8g to 8g+7. No other line has any effect on the words produced.
- R2: While sampling, one bit is taken from each selected line on every clock edge. A word is complete and stored after eight consecutive sample edges, so at most one word is stored per eight cycles.
- R3: Word layout: line 8g+k fills byte k (bits 8k+7 down to 8k), and bit 8k+j holds the j-th sample of the word, with j=0 the oldest.
- R4: The store holds up to 64 words and returns them in the order they were stored. `fill_count` gives the number of stored words.
- R5: `fifo_full` is high when 64 words are stored. While it is high, sampling pauses and no stored word is lost or overwritten.
- R6: After a word is read from a full store, sampling resumes on the next edge. The store is full again eight edges later.
- R7: The first sample taken after sampling starts is forced to 0 on every line, so bit 8k of the first word is 0.
- R8: A read request seen at a clock edge produces `rd_valid` high for the following cycle, with the oldest word on `rd_data`. If the store is empty, `rd_data` is 0 and `rd_underflow` is high instead.
- R9: While `ctl_clear` is high the store empties, the count and full flag read 0, and no sampling happens. When clear is released, the first sample is again forced to 0.
- R10: Sampling happens only while `ctl_enable` and `ctl_raw` are both high. Dropping either one discards the word being built.
- R11: A change of `ctl_group` discards the word being built. A new word starts with the sample taken on that same edge from the new group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_bits | input | 128 | Current sample bit of every oscillator |
| ctl_enable | input | 1 | Unit enable |
| ctl_raw | input | 1 | Raw sampling mode select |
| ctl_group | input | 4 | Oscillator group select |
| ctl_clear | input | 1 | Clear the store and hold the unit idle |
| rd_req | input | 1 | Pop one word |
| rd_data | output | 64 | Popped word, or 0 on underflow |
| rd_valid | output | 1 | High for the cycle after a read request |
| rd_underflow | output | 1 | The read found the store empty |
| fill_count | output | 7 | Number of stored words |
| fifo_full | output | 1 | Store holds 64 words |

## Verification
The oscillator lines are driven with a per-cycle hashed pattern that is different on every line and every cycle. Each bit of a word can therefore appear in only one group, byte and position, which separates wrong group decoding, wrong byte order, reversed sample order and an off-by-one sampling edge. An all-ones pattern leaves only the forced first-sample zeros visible, which isolates that rule and makes the refill words easy to tell apart. Runs that change the group partway through a word, and that sample two groups back to back, show that partial words are discarded and that the store keeps its order.

// File: rtl/ro_entropy_pkg.sv
package ro_entropy_pkg;

  // Occupancy after one edge with the given push and pop events.
  function automatic int unsigned step_count(int unsigned cnt, logic push, logic pop);
    int unsigned r;
    r = cnt;
    if (push) r = r + 1;
    if (pop)  r = r - 1;
    return r;
  endfunction

  // Circular slot advance for a store of the given depth.
  function automatic int unsigned next_slot(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Index of the lowest line of a group.
  function automatic int unsigned group_base(int unsigned grp, int unsigned lanes);
    return grp * lanes;
  endfunction

endpackage

// File: rtl/ro_group_select.sv
module ro_group_select #(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned LANES   = 8,
  localparam int unsigned NGRP   = NUM_SRC / LANES,
  localparam int unsigned GW     = $clog2(NGRP),
  localparam int unsigned IW     = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] osc_bits,
  input  logic [GW-1:0]      grp,
  output logic [LANES-1:0]   lane_bits
);
  logic [IW-1:0] base;
  assign base = IW'(ro_entropy_pkg::group_base(32'(grp), LANES));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bits[k] = osc_bits[base + IW'(k)];
  end
endmodule

// File: rtl/ro_lane_packer.sv
module ro_lane_packer #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned SAMPLES = 8,
  localparam int unsigned CW     = $clog2(SAMPLES),
  localparam int unsigned WORD_W = LANES * SAMPLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              advance,
  input  logic              restart,
  input  logic [LANES-1:0]  samp,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(SAMPLES - 1));
  assign push = advance & ~restart & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (advance)    cnt <= restart ? CW'(1) : (last ? '0 : cnt + CW'(1));
    else if (restart)    cnt <= '0;
  end

  // One shift register per line; newest sample enters at the top.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SAMPLES-2:0] acc;
    logic [SAMPLES-1:0] nxt;
    assign nxt = {samp[k], acc};
    assign word[k*SAMPLES +: SAMPLES] = nxt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (advance) acc <= nxt[SAMPLES-1:1];
    end
  end
endmodule

// File: rtl/ro_word_fifo.sv
module ro_word_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             rd_req,
  output logic             pop,
  output logic [W-1:0]     rd_data,
  output logic             rd_valid,
  output logic             rd_underflow,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, empty;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign pop     = rd_req & ~clr & ~empty;
  assign push_ok = push & ~clr & (~full | pop);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
      rd_data <= '0; rd_valid <= 1'b0; rd_underflow <= 1'b0;
    end else if (clr) begin
      wptr <= '0; rptr <= '0; count <= '0;
      rd_data <= '0; rd_valid <= 1'b0; rd_underflow <= 1'b0;
    end else begin
      if (push_ok) wptr <= AW'(ro_entropy_pkg::next_slot(32'(wptr), DEPTH));
      if (pop)     rptr <= AW'(ro_entropy_pkg::next_slot(32'(rptr), DEPTH));
      count <= CNT_W'(ro_entropy_pkg::step_count(32'(count), push_ok, pop));
      rd_valid     <= rd_req;
      rd_underflow <= rd_req & empty;
      if (rd_req) rd_data <= empty ? '0 : mem[rptr];
    end
  end
endmodule

// File: rtl/ro_entropy_packer.sv
module ro_entropy_packer #(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned LANES   = 8,
  parameter int unsigned SAMPLES = 8,
  parameter int unsigned DEPTH   = 64,
  localparam int unsigned NGRP   = NUM_SRC / LANES,
  localparam int unsigned GW     = $clog2(NGRP),
  localparam int unsigned WORD_W = LANES * SAMPLES,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] osc_bits,
  input  logic              ctl_enable,
  input  logic              ctl_raw,
  input  logic [GW-1:0]     ctl_group,
  input  logic              ctl_clear,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_underflow,
  output logic [CNT_W-1:0]  fill_count,
  output logic              fifo_full
);
  // Named internal events, observed by the bound checker.
  logic              run_en, advance, grp_change, primed;
  logic              push_evt, pop_evt;
  logic [GW-1:0]     grp_q;
  logic [LANES-1:0]  lane_raw, lane_bits;
  logic [WORD_W-1:0] packed_word;

  assign run_en     = ctl_enable & ctl_raw & ~ctl_clear;
  assign advance    = run_en & ~fifo_full;
  assign grp_change = (ctl_group != grp_q);
  // First sample after start carries no entropy: forced low.
  assign lane_bits  = lane_raw & {LANES{primed}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      primed <= 1'b0;
    end else begin
      grp_q <= ctl_group;
      if (!run_en)      primed <= 1'b0;
      else if (advance) primed <= 1'b1;
    end
  end

  ro_group_select #(.NUM_SRC(NUM_SRC), .LANES(LANES)) u_sel (
    .osc_bits (osc_bits),
    .grp      (ctl_group),
    .lane_bits(lane_raw)
  );

  ro_lane_packer #(.LANES(LANES), .SAMPLES(SAMPLES)) u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_en),
    .advance(advance),
    .restart(grp_change),
    .samp   (lane_bits),
    .push   (push_evt),
    .word   (packed_word)
  );

  ro_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (ctl_clear),
    .push        (push_evt),
    .wdata       (packed_word),
    .rd_req      (rd_req),
    .pop         (pop_evt),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .rd_underflow(rd_underflow),
    .count       (fill_count),
    .full        (fifo_full)
  );
endmodule

// File: rtl/ro_entropy_packer_chk.sv
module ro_entropy_packer_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned DEPTH  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic              ctl_raw,
  input logic              ctl_clear,
  input logic              rd_req,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_underflow,
  input logic [CNT_W-1:0]  fill_count,
  input logic              fifo_full,
  input logic              push_evt,
  input logic              pop_evt
);
  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(DEPTH));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_clear && push_evt && !pop_evt) |=> fill_count == $past(fill_count) + CNT_W'(1));

  // R5
  full_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_req) |-> !push_evt);

  // R2
  word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> !push_evt);

  // R8
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fill_count == '0 && !ctl_clear) |=> (rd_underflow && rd_data == '0));

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> (fill_count == '0 && !fifo_full));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enable || !ctl_raw || ctl_clear) |-> !push_evt);
endmodule

bind ro_entropy_packer ro_entropy_packer_chk #(
  .WORD_W(WORD_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_enable  (ctl_enable),
  .ctl_raw     (ctl_raw),
  .ctl_clear   (ctl_clear),
  .rd_req      (rd_req),
  .rd_data     (rd_data),
  .rd_underflow(rd_underflow),
  .fill_count  (fill_count),
  .fifo_full   (fifo_full),
  .push_evt    (push_evt),
  .pop_evt     (pop_evt)
);

// File: tb/ro_entropy_packer_tb.sv
module ro_entropy_packer_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] osc_bits;
  logic         ctl_enable, ctl_raw, ctl_clear, rd_req;
  logic [3:0]   ctl_group;
  logic [63:0]  rd_data;
  logic         rd_valid, rd_underflow, fifo_full;
  logic [6:0]   fill_count;

  int checks = 0;
  int errs   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ro_entropy_packer u_dut (
    .clk(clk), .rst_n(rst_n), .osc_bits(osc_bits),
    .ctl_enable(ctl_enable), .ctl_raw(ctl_raw), .ctl_group(ctl_group),
    .ctl_clear(ctl_clear), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_underflow(rd_underflow),
    .fill_count(fill_count), .fifo_full(fifo_full)
  );

  // Hashed pattern: distinct on every line and every cycle.
  function automatic logic [127:0] gen(logic [31:0] seed, int i);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] v;
      v = (seed * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ (32'(w) * 32'h85EB_CA6B);
      v = v ^ (v >> 13);
      v = v * 32'hC2B2_AE35;
      v = v ^ (v >> 16);
      r[w*32 +: 32] = v;
    end
    return r;
  endfunction

  // Expected word n of a run: byte k from line 8g+k, bit j = j-th sample.
  function automatic logic [63:0] exp_word(logic [31:0] seed, int grp, int n, bit first);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 8; j++) begin
        logic [127:0] s;
        s = gen(seed, 8 * n + j);
        r[k*8 + j] = (first && j == 0) ? 1'b0 : s[grp*8 + k];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) ctl_clear = 1'b1;
    @(negedge clk) ctl_clear = 1'b0;
  endtask

  task automatic drive(logic [31:0] seed, int n);
    for (int i = 0; i < n; i++) begin
      osc_bits = gen(seed, i);
      @(negedge clk);
    end
  endtask

  task automatic read_word(output logic [63:0] d, output logic v, output logic u);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    d = rd_data; v = rd_valid; u = rd_underflow;
  endtask

  task automatic t_reset();
    check("R4 reset fill_count", 64'(fill_count), 64'd0);
    check("R5 reset fifo_full", 64'(fifo_full), 64'd0);
    check("R8 reset rd_valid", 64'(rd_valid), 64'd0);
    check("R8 reset rd_data", rd_data, 64'd0);
  endtask

  task automatic t_single(int grp, logic [31:0] seed);
    logic [63:0] d; logic v, u;
    do_clear();
    ctl_group = 4'(grp);
    @(negedge clk) ctl_enable = 1'b1;
    drive(seed, 8);
    ctl_enable = 1'b0;
    check("R2 one word after 8 samples", 64'(fill_count), 64'd1);
    read_word(d, v, u);
    check("R8 rd_valid", 64'(v), 64'd1);
    check("R1 R3 R7 single word layout", d, exp_word(seed, grp, 0, 1'b1));
  endtask

  task automatic t_multi(int grp, logic [31:0] seed, int nw);
    logic [63:0] d; logic v, u;
    do_clear();
    ctl_group = 4'(grp);
    @(negedge clk) ctl_enable = 1'b1;
    drive(seed, 8 * nw);
    ctl_enable = 1'b0;
    check("R4 fill_count after run", 64'(fill_count), 64'(nw));
    for (int n = 0; n < nw; n++) begin
      read_word(d, v, u);
      check($sformatf("R3 R4 word %0d group %0d", n, grp), d, exp_word(seed, grp, n, n == 0));
    end
  endtask

  task automatic t_underflow();
    logic [63:0] d; logic v, u;
    do_clear();
    read_word(d, v, u);
    check("R8 underflow flag", 64'(u), 64'd1);
    check("R8 underflow data", d, 64'd0);
    check("R8 underflow valid", 64'(v), 64'd1);
  endtask

  task automatic t_full_refill();
    logic [63:0] d; logic v, u;
    do_clear();
    ctl_group = 4'd7;
    osc_bits = '1;
    @(negedge clk) ctl_enable = 1'b1;
    repeat (600) @(negedge clk);
    check("R5 full count", 64'(fill_count), 64'd64);
    check("R5 full flag", 64'(fifo_full), 64'd1);
    repeat (20) @(negedge clk);
    check("R5 paused while full", 64'(fill_count), 64'd64);
    read_word(d, v, u);
    check("R7 R5 oldest word kept", d, 64'hFEFE_FEFE_FEFE_FEFE);
    repeat (3) @(negedge clk);
    check("R6 refill in progress", 64'(fill_count), 64'd63);
    repeat (6) @(negedge clk);
    check("R6 refilled", 64'(fill_count), 64'd64);
    read_word(d, v, u);
    check("R6 second word", d, 64'hFFFF_FFFF_FFFF_FFFF);
    ctl_enable = 1'b0;
  endtask

  task automatic t_clear_hold();
    logic [63:0] d; logic v, u;
    osc_bits = '1;
    ctl_group = 4'd3;
    @(negedge clk) ctl_enable = 1'b1;
    repeat (20) @(negedge clk);
    @(negedge clk) ctl_clear = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 clear empties", 64'(fill_count), 64'd0);
    check("R9 clear drops full", 64'(fifo_full), 64'd0);
    ctl_clear = 1'b0;
    repeat (9) @(negedge clk);
    check("R9 resumes after clear", 64'(fill_count), 64'd1);
    ctl_enable = 1'b0;
    read_word(d, v, u);
    check("R9 R7 first sample zero after clear", d, 64'hFEFE_FEFE_FEFE_FEFE);
  endtask

  task automatic t_raw_off();
    do_clear();
    osc_bits = '1;
    ctl_raw = 1'b0;
    @(negedge clk) ctl_enable = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 no words with raw mode off", 64'(fill_count), 64'd0);
    ctl_enable = 1'b0;
    ctl_raw = 1'b1;
    // Partial word dropped when enable falls mid-word
    @(negedge clk) ctl_enable = 1'b1;
    repeat (5) @(negedge clk);
    ctl_enable = 1'b0;
    @(negedge clk) ctl_enable = 1'b1;
    repeat (5) @(negedge clk);
    ctl_enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 partial word discarded on disable", 64'(fill_count), 64'd0);
  endtask

  task automatic t_group_change();
    logic [63:0] d; logic v, u;
    do_clear();
    ctl_group = 4'd2;
    @(negedge clk) ctl_enable = 1'b1;
    drive(32'h0000_1111, 3);
    ctl_group = 4'd5;
    drive(32'h0000_2222, 8);
    ctl_enable = 1'b0;
    check("R11 partial word discarded", 64'(fill_count), 64'd1);
    read_word(d, v, u);
    check("R11 R1 word from new group", d, exp_word(32'h0000_2222, 5, 0, 1'b0));
  endtask

  initial begin
    rst_n = 1'b0; osc_bits = '0; ctl_enable = 1'b0; ctl_raw = 1'b1;
    ctl_clear = 1'b0; rd_req = 1'b0; ctl_group = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(0, 32'hA5A5_0001);
    t_single(9, 32'h1234_5678);
    t_multi(15, 32'hCAFE_0003, 3);
    t_multi(4, 32'h0BAD_F00D, 5);
    t_underflow();
    t_full_refill();
    t_clear_hold();
    t_raw_off();
    t_group_change();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule